// File: doc/BRIEF.md
# Tracking Converter Angle Latch and Byte Bus

This block sits between the up/down position counter of a tracking angle converter and a host that reads the angle over an 8-bit bus. Each count-step request moves the 16-bit position by one LSB, up or down. Every step is announced by a fixed-length busy pulse. The new position is applied half-way through that pulse, so it is settled before busy drops.

A transparent holding register follows the position counter until the host pulls the active-low inhibit. The register then freezes while the counter keeps tracking. The host may pull inhibit at any time without watching busy. If a busy pulse is running, the freeze waits until that pulse has finished, so the frozen word always holds the completed step.

The held word is read one byte at a time through two active-low byte enables. The bus output-enable marks the cycles in which the block drives the bus. A tri-state pad or a bus mux outside the block uses it to return the bus to high impedance.

Top module: `angle_latch_if`

## Requirements
- R1: After reset the held word is 0x0000, busy is low and the bus output-enable is low.
- R2: A step request sampled while busy is low raises busy at that clock edge, and busy stays high for exactly BUSY_CYC clock cycles (default 4).
- R3: A step with direction input 1 adds one to the position, and a step with direction 0 subtracts one. While inhibit is high the new value is on the bus in the first cycle in which busy is low again.
- R4: A step request sampled while busy is high is ignored. The position changes by one LSB only, and busy ends on schedule.
- R5: The position wraps modulo 2^16: a decrement from 0x0000 gives 0xFFFF, and an increment from 0xFFFF gives 0x0000.
- R6: Inhibit (active low) sampled low with busy low freezes the held word at that edge. Later steps leave the bus word unchanged while inhibit stays low.
- R7: Inhibit sampled low while busy is high does not freeze the word. The freeze takes place at the first edge with busy low, and the word then holds the position including the step in progress.
- R8: When inhibit is sampled high, the held word reloads the current position at that clock edge. The bus word is unchanged before that edge.
- R9: With the upper enable low, the bus carries word bits 15:8 and the output-enable is high. With only the lower enable low, it carries bits 7:0. With both enables low, the upper byte wins.
- R10: With both enables high, the output-enable is low and the data lines are 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_req | input | 1 | Request one LSB step of the position |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| inhibit_n | input | 1 | Freeze the held word, active low |
| en_hi_n | input | 1 | Drive the upper byte onto the bus, active low |
| en_lo_n | input | 1 | Drive the lower byte onto the bus, active low |
| busy | output | 1 | High for BUSY_CYC cycles per accepted step |
| bus_data | output | 8 | Byte driven onto the host bus |
| bus_oe | output | 1 | High while bus_data is driven; low means high impedance |

## Verification
With BUSY_CYC at 4, busy is checked high in the four cycles after the request edge and low in the fifth. The stepped word is read in that fifth cycle, since the position register and then the holding register each add one edge. A freeze or release takes effect one edge after inhibit is sampled, so the bus word is read both before and after that edge. The byte enables act combinationally, so the bench changes them half a cycle away from any edge and samples one nanosecond later. All stimulus changes on falling edges and all sampling happens between edges.

// File: rtl/alc_pkg.sv
package alc_pkg;

    // Source currently selected for the host byte bus.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HI   = 2'd1,
        SRC_LO   = 2'd2
    } bus_src_e;

endpackage

// File: rtl/alc_step_seq.sv
// Position counter with fixed-length busy pulse; the count moves mid-pulse.
module alc_step_seq #(
    parameter int WORD_W   = 16,
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_req,
    input  logic              step_up,
    output logic [WORD_W-1:0] pos,
    output logic              busy
);
    localparam int CNT_W   = $clog2(BUSY_CYC + 1);
    localparam int MID_RAW = BUSY_CYC / 2;
    localparam int MID_CNT = (MID_RAW < 2) ? 2 : MID_RAW;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              up;
        logic [WORD_W-1:0] pos;
    } seq_t;

    seq_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            if (step_req) begin
                st_d.cnt = CNT_W'(BUSY_CYC);
                st_d.up  = step_up;
            end
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            if (st_q.cnt == CNT_W'(MID_CNT)) begin
                st_d.pos = st_q.up ? (st_q.pos + WORD_W'(1))
                                   : (st_q.pos - WORD_W'(1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos  = st_q.pos;
    assign busy = (st_q.cnt != '0);

endmodule

// File: rtl/alc_hold_ctl.sv
// Transparent holding register with a busy-deferred freeze.
module alc_hold_ctl #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inhibit_n,
    input  logic              busy,
    input  logic [WORD_W-1:0] pos,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic              frozen;
        logic [WORD_W-1:0] held;
    } hold_t;

    hold_t hq_q, hq_d;
    logic  frozen_q;

    always_comb begin
        hq_d = hq_q;
        // Freeze only when no step is in flight; stay frozen while inhibited.
        hq_d.frozen = !inhibit_n && (hq_q.frozen || !busy);
        if (!(hq_q.frozen && !inhibit_n)) begin
            hq_d.held = pos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hq_q <= '0;
        end else begin
            hq_q <= hq_d;
        end
    end

    assign word     = hq_q.held;
    assign frozen_q = hq_q.frozen;

endmodule

// File: rtl/alc_byte_bus.sv
// Byte selector for the host bus; upper byte has priority.
module alc_byte_bus #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [WORD_W-1:0] word,
    input  logic              en_hi_n,
    input  logic              en_lo_n,
    output logic [BYTE_W-1:0] bus_data,
    output logic              bus_oe
);
    import alc_pkg::*;

    localparam int NUM_BYTES = WORD_W / BYTE_W;
    localparam int HI_IDX    = NUM_BYTES - 1;

    logic [BYTE_W-1:0] byte_arr [NUM_BYTES];
    bus_src_e          src;

    for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_slice
        assign byte_arr[gi] = word[gi*BYTE_W +: BYTE_W];
    end

    always_comb begin
        if (!en_hi_n) begin
            src = SRC_HI;
        end else if (!en_lo_n) begin
            src = SRC_LO;
        end else begin
            src = SRC_NONE;
        end
    end

    always_comb begin
        unique case (src)
            SRC_HI: begin
                bus_data = byte_arr[HI_IDX];
                bus_oe   = 1'b1;
            end
            SRC_LO: begin
                bus_data = byte_arr[0];
                bus_oe   = 1'b1;
            end
            default: begin
                bus_data = '0;
                bus_oe   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/angle_latch_if.sv
// Top: position counter, holding register and host byte bus.
module angle_latch_if #(
    parameter int WORD_W   = 16,
    parameter int BYTE_W   = 8,
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_req,
    input  logic              step_up,
    input  logic              inhibit_n,
    input  logic              en_hi_n,
    input  logic              en_lo_n,
    output logic              busy,
    output logic [BYTE_W-1:0] bus_data,
    output logic              bus_oe
);
    logic [WORD_W-1:0] pos;
    logic [WORD_W-1:0] word;

    alc_step_seq #(
        .WORD_W   (WORD_W),
        .BUSY_CYC (BUSY_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_req (step_req),
        .step_up  (step_up),
        .pos      (pos),
        .busy     (busy)
    );

    alc_hold_ctl #(
        .WORD_W (WORD_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .inhibit_n (inhibit_n),
        .busy      (busy),
        .pos       (pos),
        .word      (word)
    );

    alc_byte_bus #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) u_bus (
        .word     (word),
        .en_hi_n  (en_hi_n),
        .en_lo_n  (en_lo_n),
        .bus_data (bus_data),
        .bus_oe   (bus_oe)
    );

endmodule

// File: rtl/alc_checker.sv
// Property checker attached to the top by bind.
module alc_checker #(
    parameter int WORD_W   = 16,
    parameter int BYTE_W   = 8,
    parameter int BUSY_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_req,
    input logic              inhibit_n,
    input logic              en_hi_n,
    input logic              en_lo_n,
    input logic              busy,
    input logic [BYTE_W-1:0] bus_data,
    input logic              bus_oe,
    input logic [WORD_W-1:0] word,
    input logic              frozen
);
    localparam int RUN_W = $clog2(BUSY_CYC + 2) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + RUN_W'(1);
        end else begin
            run_q <= '0;
        end
    end

    assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_req && !busy) |=> busy);

    // Extra requests during busy must not stretch the pulse (R4).
    assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(BUSY_CYC)));

    assert_word_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !inhibit_n) |=> $stable(word));

    assert_no_freeze_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && busy) |=> !frozen);

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_n |=> !frozen);

    assert_hi_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_hi_n |-> (bus_oe && bus_data == word[WORD_W-1 -: BYTE_W]));

    assert_bus_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hi_n && en_lo_n) |-> (!bus_oe && bus_data == '0));

endmodule

bind angle_latch_if alc_checker #(
    .WORD_W   (WORD_W),
    .BYTE_W   (BYTE_W),
    .BUSY_CYC (BUSY_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_req  (step_req),
    .inhibit_n (inhibit_n),
    .en_hi_n   (en_hi_n),
    .en_lo_n   (en_lo_n),
    .busy      (busy),
    .bus_data  (bus_data),
    .bus_oe    (bus_oe),
    .word      (word),
    .frozen    (u_hold.frozen_q)
);

// File: tb/tb_angle_latch_if.sv
module tb_angle_latch_if;
    localparam int BUSY_CYC = 4;
    localparam int NVEC     = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_req = 1'b0;
    logic       step_up = 1'b0;
    logic       inhibit_n = 1'b1;
    logic       en_hi_n = 1'b1;
    logic       en_lo_n = 1'b1;
    logic       busy;
    logic [7:0] bus_data;
    logic       bus_oe;

    int n_chk  = 0;
    int n_fail = 0;

    // {direction, expected word after the step}, starting from 0x0000.
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 16'hFFFF},
        {1'b1, 16'h0000},
        {1'b1, 16'h0001},
        {1'b1, 16'h0002},
        {1'b0, 16'h0001},
        {1'b1, 16'h0002},
        {1'b1, 16'h0003}
    };

    angle_latch_if #(.WORD_W(16), .BYTE_W(8), .BUSY_CYC(BUSY_CYC)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_req  (step_req),
        .step_up   (step_up),
        .inhibit_n (inhibit_n),
        .en_hi_n   (en_hi_n),
        .en_lo_n   (en_lo_n),
        .busy      (busy),
        .bus_data  (bus_data),
        .bus_oe    (bus_oe)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Reads both bytes; call shortly after a falling edge.
    task automatic read_word(output logic [15:0] w);
        en_hi_n = 1'b0;
        #1;
        w[15:8] = bus_data;
        en_hi_n = 1'b1;
        en_lo_n = 1'b0;
        #1;
        w[7:0] = bus_data;
        en_lo_n = 1'b1;
        #1;
    endtask

    // One step; checks busy for BUSY_CYC cycles, then low. Ends just past a falling edge.
    task automatic do_step(input logic dir, input bit extra_req, input string req);
        @(negedge clk);
        step_req = 1'b1;
        step_up  = dir;
        @(negedge clk);
        step_req = extra_req;
        step_up  = ~dir;
        check(busy === 1'b1, req, {31'd0, busy}, 32'd1);
        for (int k = 1; k < BUSY_CYC; k++) begin
            @(negedge clk);
            step_req = 1'b0;
            check(busy === 1'b1, req, {31'd0, busy}, 32'd1);
        end
        @(negedge clk);
        check(busy === 1'b0, req, {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [15:0] model;
        // R1: reset state
        #1;
        check(busy === 1'b0, "R1 busy", {31'd0, busy}, 32'd0);
        check(bus_oe === 1'b0, "R1 oe", {31'd0, bus_oe}, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_word(w);
        check(w === 16'h0000, "R1 word", {16'd0, w}, 32'h0);

        // R2 R3 R5: table of steps, wrap both ways
        for (int i = 0; i < NVEC; i++) begin
            do_step(VEC[i][16], 1'b0, "R2 busy");
            read_word(w);
            check(w === VEC[i][15:0], "R3/R5 step word", {16'd0, w}, {16'd0, VEC[i][15:0]});
        end
        model = 16'h0003;

        // R9 R10: byte enables
        @(negedge clk);
        en_hi_n = 1'b0; en_lo_n = 1'b0;
        #1;
        check(bus_oe === 1'b1 && bus_data === model[15:8], "R9 both enables",
              {23'd0, bus_oe, bus_data}, {23'd0, 1'b1, model[15:8]});
        en_hi_n = 1'b1;
        #1;
        check(bus_oe === 1'b1 && bus_data === model[7:0], "R9 lower",
              {23'd0, bus_oe, bus_data}, {23'd0, 1'b1, model[7:0]});
        en_lo_n = 1'b1;
        #1;
        check(bus_oe === 1'b0 && bus_data === 8'h00, "R10 idle",
              {23'd0, bus_oe, bus_data}, 32'd0);

        // R4: second request during busy ignored
        do_step(1'b1, 1'b1, "R4 busy");
        model = model + 16'd1;
        read_word(w);
        check(w === model, "R4 single step", {16'd0, w}, {16'd0, model});
        repeat (BUSY_CYC + 2) @(negedge clk);
        check(busy === 1'b0, "R4 no late pulse", {31'd0, busy}, 32'd0);
        read_word(w);
        check(w === model, "R4 word kept", {16'd0, w}, {16'd0, model});

        // R6: freeze with busy low, then steps do not reach the bus
        @(negedge clk);
        inhibit_n = 1'b0;
        do_step(1'b1, 1'b0, "R6 busy");
        do_step(1'b1, 1'b0, "R6 busy");
        read_word(w);
        check(w === model, "R6 frozen word", {16'd0, w}, {16'd0, model});

        // R8: release reloads on the next edge
        @(negedge clk);
        inhibit_n = 1'b1;
        #1;
        read_word(w);
        check(w === model, "R8 before edge", {16'd0, w}, {16'd0, model});
        model = model + 16'd2;
        @(negedge clk);
        read_word(w);
        check(w === model, "R8 after edge", {16'd0, w}, {16'd0, model});

        // R7: inhibit during busy waits for the step to finish
        @(negedge clk);
        step_req = 1'b1;
        step_up  = 1'b1;
        @(negedge clk);
        step_req  = 1'b0;
        inhibit_n = 1'b0;
        check(busy === 1'b1, "R7 busy", {31'd0, busy}, 32'd1);
        repeat (BUSY_CYC + 2) @(negedge clk);
        model = model + 16'd1;
        do_step(1'b1, 1'b0, "R7 busy");
        read_word(w);
        check(w === model, "R7 deferred freeze", {16'd0, w}, {16'd0, model});
        @(negedge clk);
        inhibit_n = 1'b1;
        @(negedge clk);
        model = model + 16'd1;
        read_word(w);
        check(w === model, "R8 release after R7", {16'd0, w}, {16'd0, model});

        summary();
        $finish;
    end

endmodule